// File: doc/BRIEF.md
# Indexed Shift Instruction Executor

This block runs one family of indexed shift and rotate instructions for an 8-bit processor. It takes the instruction one byte per cycle from a byte-wide fetch port. It adds a signed displacement to one of two 16-bit index registers to form an address. It reads the operand byte at that address, applies one of eight shift or rotate operations and writes the result back to the same address. Most encodings also copy the result into one of seven 8-bit registers through a register-file write port.

The instruction has four bytes. First comes a prefix that picks the index register. Then comes a fixed byte 0xCB, then the displacement, and last the byte that picks the operation and destination. After the last byte the block runs a read cycle, then a write cycle, then an optional register write cycle. It ends with a one-cycle completion pulse. The carry input feeds the two rotate-through-carry operations. The flag outputs hold the flags of the most recent result.

Top module: `idx_shift_exec`

## Requirements
- R1: A byte is taken when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high only while the block waits for one of the four instruction bytes, and it is low during the read, write and register cycles.
- R2: A first byte of 0xDD selects `index_x` and 0xFD selects `index_y`. The address is the selected index plus the third byte sign-extended to 16 bits, wrapping modulo 65536.
- R3: The operation byte is laid out as bits 7:6 = 00, bits 5:3 = operation, bits 2:0 = register. Operation 000 rotates left with bit 7 into bit 0. 001 rotates right with bit 0 into bit 7. 010 rotates left through `carry_in`. 011 rotates right through `carry_in`. 100 shifts left with 0 into bit 0. 101 shifts right keeping bit 7. 110 shifts left with 1 into bit 0. 111 shifts right with 0 into bit 7. The result is written to memory.
- R4: The flags come from the result. Carry is the bit shifted out, zero is set when the result is 0, sign is result bit 7, and parity is 1 when the number of ones is even. `flag_h` and `flag_n` are 0. The flags are valid from the write cycle onward.
- R5: For register codes 000 B, 001 C, 010 D, 011 E, 100 H, 101 L and 111 A, the cycle after the memory write drives `reg_we` with `reg_sel` equal to the code and `reg_wdata` equal to the written byte.
- R6: Register code 110 writes only to memory, and `reg_we` stays low for the whole instruction.
- R7: `mem_rd` is high in the cycle after the operation byte is taken, and `mem_wr` is high in the cycle after that. Both cycles use the same address.
- R8: `done` pulses for one cycle after the last write. In that same cycle `in_ready` is high, so the next instruction's first byte can be taken then.
- R9: A first byte other than 0xDD or 0xFD, or a second byte other than 0xCB, gives a one-cycle `illegal` pulse in the next cycle. The block then waits for a new first byte and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction byte present |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Block can take a byte |
| index_x | input | 16 | Index register picked by 0xDD |
| index_y | input | 16 | Index register picked by 0xFD |
| carry_in | input | 1 | Carry used by the through-carry rotates |
| mem_addr | output | 16 | Operand address |
| mem_rd | output | 1 | Read strobe; data sampled on the same edge |
| mem_rdata | input | 8 | Read data |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| reg_we | output | 1 | Register write enable |
| reg_sel | output | 3 | Destination register code |
| reg_wdata | output | 8 | Register write data |
| flag_c | output | 1 | Carry flag |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_p | output | 1 | Parity flag (even) |
| flag_h | output | 1 | Half-carry flag, always 0 |
| flag_n | output | 1 | Subtract flag, always 0 |
| done | output | 1 | Instruction complete pulse |
| illegal | output | 1 | Bad prefix sequence pulse |

## Verification
Two things can happen in the same cycle: the completion pulse of one instruction and the taking of the first byte of the next one. The bench provokes this by issuing every instruction with no gap after the one before. In the pulse cycle it checks that `done` and `in_ready` are both high, and then it checks the next instruction in full. The same gap-free scheme also puts a bad first byte into a completion cycle. There the bench checks that `illegal` follows alone and that a later legal instruction still runs correctly.

// File: rtl/idx_shift_exec.sv
module idx_shift_exec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic [15:0] index_x,
  input  logic [15:0] index_y,
  input  logic        carry_in,
  output logic [15:0] mem_addr,
  output logic        mem_rd,
  input  logic [7:0]  mem_rdata,
  output logic        mem_wr,
  output logic [7:0]  mem_wdata,
  output logic        reg_we,
  output logic [2:0]  reg_sel,
  output logic [7:0]  reg_wdata,
  output logic        flag_c,
  output logic        flag_z,
  output logic        flag_s,
  output logic        flag_p,
  output logic        flag_h,
  output logic        flag_n,
  output logic        done,
  output logic        illegal
);
  localparam logic [7:0] PFX_X = 8'hDD;
  localparam logic [7:0] PFX_Y = 8'hFD;
  localparam logic [7:0] ESC   = 8'hCB;
  localparam logic [2:0] MEM_ONLY = 3'b110;

  typedef enum logic [2:0] {S_PFX, S_ESC, S_DISP, S_OP, S_RD, S_WR, S_REG} st_t;
  st_t st;

  logic       use_y;
  logic [7:0] disp, res;
  logic [2:0] op, rsel;
  logic [7:0] sh_res;
  logic       sh_c;
  logic       take;

  assign take     = in_valid && in_ready;
  assign in_ready = (st == S_PFX) || (st == S_ESC) || (st == S_DISP) || (st == S_OP);
  assign mem_addr = (use_y ? index_y : index_x) + {{8{disp[7]}}, disp};
  assign mem_rd   = (st == S_RD);
  assign mem_wr   = (st == S_WR);
  assign mem_wdata = res;
  assign reg_we    = (st == S_REG);
  assign reg_sel   = rsel;
  assign reg_wdata = res;
  assign flag_h    = 1'b0;
  assign flag_n    = 1'b0;

  always_comb begin
    case (op)
      3'd0: {sh_c, sh_res} = {mem_rdata[7], mem_rdata[6:0], mem_rdata[7]};
      3'd1: {sh_c, sh_res} = {mem_rdata[0], mem_rdata[0], mem_rdata[7:1]};
      3'd2: {sh_c, sh_res} = {mem_rdata[7], mem_rdata[6:0], carry_in};
      3'd3: {sh_c, sh_res} = {mem_rdata[0], carry_in, mem_rdata[7:1]};
      3'd4: {sh_c, sh_res} = {mem_rdata[7], mem_rdata[6:0], 1'b0};
      3'd5: {sh_c, sh_res} = {mem_rdata[0], mem_rdata[7], mem_rdata[7:1]};
      3'd6: {sh_c, sh_res} = {mem_rdata[7], mem_rdata[6:0], 1'b1};
      default: {sh_c, sh_res} = {mem_rdata[0], 1'b0, mem_rdata[7:1]};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_PFX;
      use_y <= 1'b0;
      disp <= '0;
      op <= '0;
      rsel <= '0;
      res <= '0;
      {flag_c, flag_z, flag_s, flag_p} <= '0;
      done <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done <= 1'b0;
      illegal <= 1'b0;
      case (st)
        S_PFX: if (take) begin
          if (in_data == PFX_X || in_data == PFX_Y) begin
            use_y <= (in_data == PFX_Y);
            st <= S_ESC;
          end else illegal <= 1'b1;
        end
        S_ESC: if (take) begin
          if (in_data == ESC) st <= S_DISP;
          else begin
            illegal <= 1'b1;
            st <= S_PFX;
          end
        end
        S_DISP: if (take) begin
          disp <= in_data;
          st <= S_OP;
        end
        S_OP: if (take) begin
          op <= in_data[5:3];
          rsel <= in_data[2:0];
          st <= S_RD;
        end
        S_RD: begin
          res <= sh_res;
          flag_c <= sh_c;
          flag_z <= (sh_res == 8'h00);
          flag_s <= sh_res[7];
          flag_p <= ~^sh_res;
          st <= S_WR;
        end
        S_WR: begin
          if (rsel != MEM_ONLY) st <= S_REG;
          else begin
            st <= S_PFX;
            done <= 1'b1;
          end
        end
        default: begin
          st <= S_PFX;
          done <= 1'b1;
        end
      endcase
    end
  end

  assert_write_follows_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd));
  assert_same_address_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr));
  assert_reg_after_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(mem_wr) && reg_wdata == $past(mem_wdata)));
  assert_no_reg_for_mem_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> reg_sel != MEM_ONLY);
  assert_zero_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> flag_z == (mem_wdata == 8'h00));
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(mem_wr) || $past(reg_we)));
  assert_illegal_no_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!mem_rd && !mem_wr && !done && in_ready));
endmodule

// File: tb/test_idx_shift_exec.sv
module test_idx_shift_exec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready;
  logic [15:0] index_x = 16'hFFF0;
  logic [15:0] index_y = 16'h0008;
  logic carry_in = 1'b0;
  logic [15:0] mem_addr;
  logic mem_rd, mem_wr, reg_we;
  logic [7:0] mem_rdata = 8'h00;
  logic [7:0] mem_wdata, reg_wdata;
  logic [2:0] reg_sel;
  logic flag_c, flag_z, flag_s, flag_p, flag_h, flag_n, done, illegal;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  idx_shift_exec i_idx_shift_exec (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .index_x(index_x), .index_y(index_y), .carry_in(carry_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_p(flag_p),
    .flag_h(flag_h), .flag_n(flag_n), .done(done), .illegal(illegal));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    chk("R1 ready before byte", int'(in_ready), 1);
    in_valid = 1'b1;
    in_data = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_instr(input bit sel_y, input int op, input int r, input int dsp,
                           input int v, input int cin);
    int idx, ea, res, c, ones, par;
    idx = sel_y ? int'(index_y) : int'(index_x);
    ea = (idx + dsp - ((dsp >= 128) ? 256 : 0) + 65536) % 65536;
    case (op)
      0: begin res = (v * 2) % 256 + v / 128; c = v / 128; end
      1: begin res = v / 2 + (v % 2) * 128; c = v % 2; end
      2: begin res = (v * 2) % 256 + cin; c = v / 128; end
      3: begin res = v / 2 + cin * 128; c = v % 2; end
      4: begin res = (v * 2) % 256; c = v / 128; end
      5: begin res = v / 2 + (v / 128) * 128; c = v % 2; end
      6: begin res = (v * 2) % 256 + 1; c = v / 128; end
      default: begin res = v / 2; c = v % 2; end
    endcase
    ones = 0;
    for (int b = 0; b < 8; b++) ones += (res >> b) & 1;
    par = (ones % 2 == 0) ? 1 : 0;
    mem_rdata = 8'(v);
    carry_in = cin[0];
    send(sel_y ? 8'hFD : 8'hDD);
    send(8'hCB);
    send(8'(dsp));
    send(8'(op * 8 + r));
    chk("R7 read strobe", int'(mem_rd), 1);
    chk("R1 not ready in read", int'(in_ready), 0);
    chk("R2 address", int'(mem_addr), ea);
    @(negedge clk);
    chk("R7 write strobe", int'({mem_rd, mem_wr}), 1);
    chk("R2 write address", int'(mem_addr), ea);
    chk("R3 result", int'(mem_wdata), res);
    chk("R4 flags czsphn", int'({flag_c, flag_z, flag_s, flag_p, flag_h, flag_n}),
        (c * 32) + ((res == 0) ? 16 : 0) + (res / 128) * 8 + par * 4);
    chk("R6 no reg write with memory write", int'(reg_we), 0);
    @(negedge clk);
    if (r != 6) begin
      chk("R5 register write", int'({reg_we, reg_sel, reg_wdata}), 2048 + r * 256 + res);
      chk("R5 memory idle", int'({mem_rd, mem_wr, done}), 0);
      @(negedge clk);
    end
    chk("R6 reg_we low at end", int'(reg_we), 0);
    chk("R8 done with ready", int'({done, in_ready, illegal}), 6);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int ops[6];
    int dsps[5];
    ops = '{0, 128, 1, 165, 255, 126};
    dsps = '{0, 127, 128, 255, 19};
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(in_ready), 1);
    chk("R8 reset outputs", int'({mem_rd, mem_wr, reg_we, done, illegal}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 2; p++)
      for (int op = 0; op < 8; op++)
        for (int r = 0; r < 8; r++)
          for (int k = 0; k < 6; k++)
            for (int ci = 0; ci < 2; ci++)
              run_instr(p[0], op, r, dsps[(k + r) % 5], ops[k], ci);
    send(8'h12);
    chk("R9 bad first byte in done cycle", int'({illegal, done, mem_rd}), 4);
    send(8'hDD);
    send(8'h00);
    chk("R9 bad second byte", int'({illegal, mem_rd, in_ready}), 5);
    @(negedge clk);
    chk("R9 pulse one cycle", int'(illegal), 0);
    send(8'hCB);
    chk("R9 0xCB as first byte", int'(illegal), 1);
    run_instr(1'b1, 7, 7, 8'hF8, 8'h01, 1);
    run_instr(1'b0, 2, 6, 8'h10, 8'h80, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule